// File: doc/BRIEF.md
# Port-Mask Scan List Builder

This block turns a set of per-board port-selection masks into a scan program for an acquisition sequencer's memory. Each of the eight boards has a 32-bit mask in which bit n picks port n. Software loads the masks through a small configuration write port while the block is idle, then pulses `start`. The block walks every board and every port, writes two-word entries through a plain write port (address, data, enable), closes the program with two zero words, and reports how many channels it emitted.

Within a board, the lowest selected port is not written in mask order. It is held back and written as that board's last entry, after all the board's other selected ports in ascending order. The first sample a board takes after a switch is therefore a settling slot. `done` pulses once the program is complete. The channel count stays valid until the next start.

Top module: `scan_list_builder`

## Requirements
- R1: After reset, `busy`, `done` and `wr_en` are 0 and `chan_count` is 0. Every board's mask holds 0x0000FFFF, so a run with no configuration selects ports 0 to 15 on all boards.
- R2: Boards are visited from 0 to 7. Within a board, every selected port except the lowest is written in ascending port order, and the lowest selected port is written last for that board.
- R3: Each entry is two 16-bit words. The first is 0x0080 OR port[4:3]. The second is 0x00C0 OR (port[2:0] << 3) OR board[2:0].
- R4: Write addresses start at 0 and rise by one for each word. A run writes exactly 2 × entries + 2 words.
- R5: The last two words of every program are 0x0000.
- R6: `chan_count` is cleared at start and rises by one with the second word of each entry, deferred ports included. It ends equal to the number of selected ports.
- R7: `done` is high for exactly one cycle, in the cycle after the final terminating word is written. `busy` is low in that cycle.
- R8: A `start` pulse while `busy` is high has no effect on the program, the count or the run length.
- R9: A configuration write (`cfg_we`, `cfg_board` selects the board, `cfg_mask` is the value) takes effect on the next run when made while idle, and is discarded when made while `busy`.
- R10: A board whose mask is zero emits no entries. With all masks zero, the program is only the two terminating words and `chan_count` is 0.
- R11: `busy` stays high for 3 + Σ over boards of (32 if the board selects nothing, else 33 + n), where n is the board's number of selected ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Mask write strobe |
| cfg_board | input | 3 | Board whose mask is written |
| cfg_mask | input | 32 | New mask value, bit n selects port n |
| start | input | 1 | Begin building a program |
| busy | output | 1 | Build in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | output | 1 | Sequencer memory write enable |
| wr_addr | output | 10 | Sequencer memory word address |
| wr_data | output | 16 | Sequencer memory word |
| chan_count | output | 9 | Channels emitted in the current or last run |

## Verification
The assertions take for granted that `start` is a pulse and that a run is started only from reset or after a previous `done`. They assume no particular mask contents, because the address, count and encoding rules must hold for any selection. The stimulus changes masks only while `busy` is low, except in one deliberate run that pulses `start` and writes a mask mid-run to show both are discarded. A sweep of single and paired port positions across all boards, plus full, empty and default masks, covers deferral at port 0, at port 31 and with a single selected port.

// File: rtl/scan_pkg.sv
package scan_pkg;

  localparam int PORT_FIELD_W  = 5;
  localparam int BOARD_FIELD_W = 3;
  localparam int WORD_W        = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_HOLD_LO,
    ST_DEFER_HI,
    ST_DEFER_LO,
    ST_TERM_A,
    ST_TERM_B,
    ST_FINISH
  } walk_state_t;

  function automatic logic [WORD_W-1:0] entry_hi(input logic [PORT_FIELD_W-1:0] port);
    return {8'h00, 2'b10, 4'b0000, port[4:3]};
  endfunction

  function automatic logic [WORD_W-1:0] entry_lo(input logic [PORT_FIELD_W-1:0] port,
                                                 input logic [BOARD_FIELD_W-1:0] board);
    return {8'h00, 2'b11, port[2:0], board};
  endfunction

endpackage

// File: rtl/scan_mask_bank.sv
module scan_mask_bank #(
  parameter int NUM_BOARDS = 8,
  parameter int NUM_PORTS  = 32,
  parameter logic [NUM_PORTS-1:0] DEFAULT_MASK = NUM_PORTS'(32'h0000_FFFF),
  localparam int BOARD_W = $clog2(NUM_BOARDS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_allow,
  input  logic                 cfg_we,
  input  logic [BOARD_W-1:0]   cfg_board,
  input  logic [NUM_PORTS-1:0] cfg_mask,
  input  logic [BOARD_W-1:0]   rd_board,
  output logic [NUM_PORTS-1:0] rd_mask
);

  logic [NUM_PORTS-1:0] mask_q [NUM_BOARDS];

  for (genvar b = 0; b < NUM_BOARDS; b++) begin : g_board
    always_ff @(posedge clk) begin
      if (rst) begin
        mask_q[b] <= DEFAULT_MASK;
      end else if (cfg_we && wr_allow && cfg_board == BOARD_W'(b)) begin
        mask_q[b] <= cfg_mask;
      end
    end
  end

  assign rd_mask = mask_q[rd_board];

endmodule

// File: rtl/scan_walker.sv
module scan_walker
  import scan_pkg::*;
#(
  parameter int NUM_BOARDS = 8,
  parameter int NUM_PORTS  = 32,
  localparam int BOARD_W = $clog2(NUM_BOARDS),
  localparam int PORT_W  = $clog2(NUM_PORTS),
  localparam int ADDR_W  = $clog2(NUM_BOARDS * NUM_PORTS * 2 + 2),
  localparam int COUNT_W = $clog2(NUM_BOARDS * NUM_PORTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [NUM_PORTS-1:0] mask,
  output logic [BOARD_W-1:0]   rd_board,
  output logic                 busy,
  output logic                 done,
  output logic                 wr_en,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [WORD_W-1:0]    wr_data,
  output logic [COUNT_W-1:0]   chan_count
);

  walk_state_t          state_q;
  logic [BOARD_W-1:0]   board_q;
  logic [PORT_W-1:0]    port_q;
  logic [PORT_W-1:0]    first_q;
  logic                 have_first_q;
  logic [ADDR_W-1:0]    ptr_q;

  logic sel, last_port, last_board;

  assign sel        = mask[port_q];
  assign last_port  = (port_q == PORT_W'(NUM_PORTS - 1));
  assign last_board = (board_q == BOARD_W'(NUM_BOARDS - 1));
  assign rd_board   = board_q;
  assign busy       = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      board_q      <= '0;
      port_q       <= '0;
      first_q      <= '0;
      have_first_q <= 1'b0;
      ptr_q        <= '0;
      chan_count   <= '0;
      wr_en        <= 1'b0;
      wr_addr      <= '0;
      wr_data      <= '0;
      done         <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      done  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q      <= ST_SCAN;
            board_q      <= '0;
            port_q       <= '0;
            have_first_q <= 1'b0;
            ptr_q        <= '0;
            chan_count   <= '0;
          end
        end

        ST_SCAN: begin
          if (sel && have_first_q) begin
            wr_en   <= 1'b1;
            wr_addr <= ptr_q;
            wr_data <= entry_hi(port_q);
            ptr_q   <= ptr_q + ADDR_W'(1);
            state_q <= ST_HOLD_LO;
          end else begin
            if (sel) begin
              have_first_q <= 1'b1;
              first_q      <= port_q;
            end
            if (!last_port) begin
              port_q <= port_q + PORT_W'(1);
            end else if (have_first_q || sel) begin
              state_q <= ST_DEFER_HI;
            end else if (last_board) begin
              state_q <= ST_TERM_A;
            end else begin
              board_q      <= board_q + BOARD_W'(1);
              port_q       <= '0;
              have_first_q <= 1'b0;
            end
          end
        end

        ST_HOLD_LO: begin
          wr_en      <= 1'b1;
          wr_addr    <= ptr_q;
          wr_data    <= entry_lo(port_q, board_q);
          ptr_q      <= ptr_q + ADDR_W'(1);
          chan_count <= chan_count + COUNT_W'(1);
          if (last_port) begin
            state_q <= ST_DEFER_HI;
          end else begin
            port_q  <= port_q + PORT_W'(1);
            state_q <= ST_SCAN;
          end
        end

        ST_DEFER_HI: begin
          wr_en   <= 1'b1;
          wr_addr <= ptr_q;
          wr_data <= entry_hi(first_q);
          ptr_q   <= ptr_q + ADDR_W'(1);
          state_q <= ST_DEFER_LO;
        end

        ST_DEFER_LO: begin
          wr_en      <= 1'b1;
          wr_addr    <= ptr_q;
          wr_data    <= entry_lo(first_q, board_q);
          ptr_q      <= ptr_q + ADDR_W'(1);
          chan_count <= chan_count + COUNT_W'(1);
          if (last_board) begin
            state_q <= ST_TERM_A;
          end else begin
            board_q      <= board_q + BOARD_W'(1);
            port_q       <= '0;
            have_first_q <= 1'b0;
            state_q      <= ST_SCAN;
          end
        end

        ST_TERM_A, ST_TERM_B: begin
          wr_en   <= 1'b1;
          wr_addr <= ptr_q;
          wr_data <= '0;
          ptr_q   <= ptr_q + ADDR_W'(1);
          state_q <= (state_q == ST_TERM_A) ? ST_TERM_B : ST_FINISH;
        end

        ST_FINISH: begin
          done    <= 1'b1;
          state_q <= ST_IDLE;
        end

        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/scan_list_builder.sv
module scan_list_builder #(
  parameter int NUM_BOARDS = 8,
  parameter int NUM_PORTS  = 32,
  localparam int BOARD_W = $clog2(NUM_BOARDS),
  localparam int ADDR_W  = $clog2(NUM_BOARDS * NUM_PORTS * 2 + 2),
  localparam int COUNT_W = $clog2(NUM_BOARDS * NUM_PORTS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [BOARD_W-1:0]   cfg_board,
  input  logic [NUM_PORTS-1:0] cfg_mask,
  input  logic                 start,
  output logic                 busy,
  output logic                 done,
  output logic                 wr_en,
  output logic [ADDR_W-1:0]    wr_addr,
  output logic [15:0]          wr_data,
  output logic [COUNT_W-1:0]   chan_count
);

  logic [BOARD_W-1:0]   rd_board;
  logic [NUM_PORTS-1:0] rd_mask;

  scan_mask_bank #(
    .NUM_BOARDS (NUM_BOARDS),
    .NUM_PORTS  (NUM_PORTS)
  ) u_masks (
    .clk       (clk),
    .rst       (rst),
    .wr_allow  (!busy),
    .cfg_we    (cfg_we),
    .cfg_board (cfg_board),
    .cfg_mask  (cfg_mask),
    .rd_board  (rd_board),
    .rd_mask   (rd_mask)
  );

  scan_walker #(
    .NUM_BOARDS (NUM_BOARDS),
    .NUM_PORTS  (NUM_PORTS)
  ) u_walker (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mask       (rd_mask),
    .rd_board   (rd_board),
    .busy       (busy),
    .done       (done),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .chan_count (chan_count)
  );

endmodule

// File: rtl/scan_list_checker.sv
module scan_list_checker #(
  parameter int ADDR_W  = 10,
  parameter int COUNT_W = 9
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic [15:0]        wr_data,
  input logic [COUNT_W-1:0] chan_count
);

  logic [ADDR_W-1:0] next_addr;

  always_ff @(posedge clk) begin
    if (rst || (start && !busy)) begin
      next_addr <= '0;
    end else if (wr_en) begin
      next_addr <= next_addr + ADDR_W'(1);
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !wr_en);

  assert_word_format_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_data == 16'h0000) ||
              (wr_data[15:6] == 10'b10 && wr_data[5:2] == 4'b0000) ||
              (wr_data[15:6] == 10'b11));

  assert_addr_sequence_R4: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> wr_addr == next_addr);

  assert_done_after_zero_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> ($past(wr_en) && $past(wr_data) == 16'h0000));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |->
      (chan_count == $past(chan_count) || 32'(chan_count) == 32'($past(chan_count)) + 1));

  assert_count_on_low_word_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && chan_count != $past(chan_count)) |->
      (wr_en && wr_data[7:6] == 2'b11));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

endmodule

bind scan_list_builder scan_list_checker #(
  .ADDR_W  (ADDR_W),
  .COUNT_W (COUNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .chan_count (chan_count)
);

// File: tb/tb_scan_list_builder.sv
`timescale 1ns/1ps
module tb_scan_list_builder;

  localparam int NB = 8;
  localparam int NP = 32;
  localparam int AW = 10;
  localparam int CW = 9;
  localparam int MAXW = 1024;

  logic          clk = 1'b0;
  logic          rst;
  logic          cfg_we;
  logic [2:0]    cfg_board;
  logic [NP-1:0] cfg_mask;
  logic          start;
  logic          busy, done, wr_en;
  logic [AW-1:0] wr_addr;
  logic [15:0]   wr_data;
  logic [CW-1:0] chan_count;

  int checks = 0;
  int errors = 0;

  logic [NP-1:0] model_mask [NB];
  logic [15:0]   exp_words [MAXW];
  logic [15:0]   got_words [MAXW];

  always #4 clk = ~clk;

  scan_list_builder #(.NUM_BOARDS(NB), .NUM_PORTS(NP)) dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_board(cfg_board),
    .cfg_mask(cfg_mask), .start(start), .busy(busy), .done(done),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .chan_count(chan_count)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_mask(input int b, input logic [NP-1:0] m);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_board = 3'(b);
    cfg_mask  = m;
    @(negedge clk);
    cfg_we    = 1'b0;
    model_mask[b] = m;
  endtask

  // poke_cycle >= 0: pulse start and write board 0 to all ones mid-run (R8, R9)
  task automatic run_check(input string tag, input int poke_cycle);
    int exp_n, exp_cnt, exp_busy, first, n, busy_n, last_wr, done_at, bad_at, cyc;
    exp_n = 0; exp_cnt = 0; exp_busy = 3;
    for (int b = 0; b < NB; b++) begin
      int sel_n;
      first = -1; sel_n = 0;
      for (int p = 0; p < NP; p++) begin
        if (model_mask[b][p]) begin
          sel_n++;
          if (first < 0) first = p;
          else begin
            exp_words[exp_n]   = 16'h0080 | 16'(p >> 3);
            exp_words[exp_n+1] = 16'h00C0 | 16'((p & 7) << 3) | 16'(b);
            exp_n += 2; exp_cnt++;
          end
        end
      end
      if (first >= 0) begin
        exp_words[exp_n]   = 16'h0080 | 16'(first >> 3);
        exp_words[exp_n+1] = 16'h00C0 | 16'((first & 7) << 3) | 16'(b);
        exp_n += 2; exp_cnt++;
      end
      exp_busy += (sel_n == 0) ? 32 : 33 + sel_n;
    end
    exp_words[exp_n] = 16'h0; exp_words[exp_n+1] = 16'h0;
    exp_n += 2;

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0; busy_n = 0; last_wr = -10; done_at = -1; bad_at = -1;
    for (cyc = 0; cyc < 4000; cyc++) begin
      if (cyc == poke_cycle) begin
        start = 1'b1; cfg_we = 1'b1; cfg_board = 3'd0; cfg_mask = '1;
      end
      if (busy) busy_n++;
      if (wr_en) begin
        if (n < MAXW) got_words[n] = wr_data;
        if (int'(wr_addr) != n && bad_at < 0) bad_at = n;
        n++; last_wr = cyc;
      end
      if (done) begin
        done_at = cyc;
        check(!busy, "R7", {tag, " busy low with done"}, busy, 0);
        break;
      end
      @(negedge clk);
      if (cyc == poke_cycle) begin start = 1'b0; cfg_we = 1'b0; end
    end
    check(done_at >= 0, "R7", {tag, " done seen"}, done_at, 0);
    check(done_at == last_wr + 1, "R7", {tag, " done one cycle after last write"}, done_at, last_wr + 1);
    check(bad_at < 0, "R4", {tag, " address sequence from 0"}, bad_at, -1);
    check(n == exp_n, "R4", {tag, " word count"}, n, exp_n);
    check(int'(chan_count) == exp_cnt, "R6", {tag, " channel count"}, chan_count, exp_cnt);
    check(busy_n == exp_busy, "R11", {tag, " busy length"}, busy_n, exp_busy);
    if (n == exp_n) begin
      int mism;
      mism = -1;
      for (int i = 0; i < exp_n - 2; i++)
        if (got_words[i] !== exp_words[i] && mism < 0) mism = i;
      check(mism < 0, "R2 R3", {tag, " entry order and encoding"},
            (mism < 0) ? 0 : got_words[mism], (mism < 0) ? 0 : exp_words[mism]);
      check(got_words[n-2] == 16'h0 && got_words[n-1] == 16'h0, "R5", {tag, " terminator"},
            {got_words[n-2], got_words[n-1]}, 0);
    end
    @(negedge clk);
    check(!done, "R7", {tag, " done is a single pulse"}, done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_board = '0; cfg_mask = '0; start = 1'b0;
    for (int b = 0; b < NB; b++) model_mask[b] = 32'h0000_FFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    check(!busy && !done && !wr_en, "R1", "idle outputs after reset", {busy, done, wr_en}, 0);
    check(chan_count == 0, "R1", "count after reset", chan_count, 0);
    run_check("R1 default masks", -1);

    for (int b = 0; b < NB; b++) set_mask(b, '1);
    run_check("R2 all ports", -1);

    // R10: all boards empty
    for (int b = 0; b < NB; b++) set_mask(b, '0);
    run_check("R10 all empty", -1);

    // R2 deferral edges: lone port 31, lone port 0, ports 0 and 31
    set_mask(0, 32'h8000_0000);
    set_mask(7, 32'h0000_0001);
    set_mask(3, 32'h8000_0001);
    run_check("R2 R10 edge ports", -1);

    // sweep: each port position, paired with a second one, on a rotating board
    for (int p = 0; p < NP; p++) begin
      for (int b = 0; b < NB; b++) set_mask(b, '0);
      set_mask(p % NB, (32'h1 << p) | (32'h1 << ((p * 7 + 3) % NP)));
      set_mask((p + 3) % NB, 32'h1 << (31 - p));
      run_check($sformatf("R2 R3 sweep p%0d", p), -1);
    end

    // sparse pseudo-random masks
    begin
      logic [31:0] lfsr;
      lfsr = 32'hACE1_2345;
      for (int r = 0; r < 4; r++) begin
        for (int b = 0; b < NB; b++) begin
          lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
          set_mask(b, lfsr & {lfsr[15:0], lfsr[31:16]});
        end
        run_check($sformatf("R6 sparse %0d", r), -1);
      end
    end

    // R8 R9: start pulse and mask write during a run are discarded
    for (int b = 0; b < NB; b++) set_mask(b, 32'h0F0F_00F0 >> b);
    run_check("R8 R9 poke mid-run", 20);
    run_check("R9 mask kept after busy write", -1);
    // R9: idle write takes effect
    set_mask(0, '1);
    run_check("R9 idle write applied", -1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule